// File: doc/BRIEF.md
# Page-Buffered Write and Address Sequencer

This block sits behind a serial-bus slave engine and in front of a small byte-wide storage array. It keeps the address pointer that every access uses. Bytes that arrive in a write transfer are collected into a page buffer. A per-slot valid flag marks which slots hold data. Nothing reaches the array until the engine reports a bus STOP. At that point the buffered bytes are committed together at the end of one timed programming period.

A busy flag is raised for the whole programming period. While it is high, every incoming event is dropped. Reads use the same pointer. The byte at the pointer is always presented on the read data output, and a read-advance event steps the pointer.

Write steps stay inside the current page. Read steps run across the whole address space.

Top module: `page_write_sequencer`

## Requirements
- R1: After reset, busy is 0, the pointer is 0 and every array byte reads as 0x00.
- R2: An address-load event sets the pointer to `addr_in`. `rd_data` always shows the array byte at the pointer.
- R3: A write-byte event stores `wr_data` in the page-buffer slot given by the low 4 pointer bits. It then increments only those 4 bits, so the upper 4 bits stay fixed. A 17th byte wraps to the first slot it used and replaces the earlier value.
- R4: The array does not change before STOP. A STOP with buffered bytes raises busy on the next clock for exactly PROG_CYCLES cycles. The buffered bytes land in the array on the clock where busy falls. Until then, `rd_data` shows the old contents.
- R5: Only page-buffer slots marked valid are written. The other bytes of the page keep their values. All valid flags clear at commit.
- R6: A STOP with no buffered bytes (an address-only transfer) does not raise busy.
- R7: A read-advance event adds 1 to all 8 pointer bits, wrapping from 0xFF to 0x00.
- R8: While busy is 1, address-load, write-byte, read-advance and stop events are ignored. The pointer and buffer are left unchanged.
- R9: After a page write, the pointer equals the last written address plus 1 within its page.
- R10: When several events arrive in one cycle, address-load wins over write-byte, and write-byte wins over read-advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_load | input | 1 | Load pointer from `addr_in` (one-cycle strobe) |
| addr_in | input | 8 | Address to load |
| wr_byte | input | 1 | Data byte received in a write transfer (strobe) |
| wr_data | input | 8 | Received data byte |
| rd_adv | input | 1 | Current read byte consumed; step pointer (strobe) |
| stop | input | 1 | Bus STOP seen (strobe) |
| rd_data | output | 8 | Array byte at the pointer |
| busy | output | 1 | Programming period in progress |

## Verification
The bench builds the block with PROG_CYCLES set to 6, with 8 address bits and a 4-bit page index. The short period makes every busy cycle observable one by one. It also leaves room to fire all four events in the middle of a programming period and to read stale data before the commit lands. With the full 256-byte space, page wrap on writes, the 17th-byte overwrite and the 0xFF-to-0x00 read wrap are all reached in a few hundred cycles.

// File: rtl/pws_pkg.sv
package pws_pkg;

    // Timer phase of the programming period
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_PROG = 1'b1
    } prog_phase_e;

    // Event decode after blocking and priority
    typedef struct packed {
        logic load;
        logic write;
        logic step;
        logic start;
    } evt_t;

endpackage

// File: rtl/pws_page_buffer.sv
module pws_page_buffer #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PAGE_W = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [PAGE_W-1:0]                    wr_idx,
    input  logic [DATA_W-1:0]                    wr_data,
    input  logic                                 clr,
    output logic [(1<<PAGE_W)-1:0]               vld,
    output logic [(1<<PAGE_W)-1:0][DATA_W-1:0]   dat,
    output logic                                 any_vld
);
    localparam int unsigned SLOTS = 1 << PAGE_W;

    typedef struct packed {
        logic [SLOTS-1:0]             vld;
        logic [SLOTS-1:0][DATA_W-1:0] dat;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (clr) begin
            buf_d.vld = '0;
        end
        if (wr_en) begin
            buf_d.vld[wr_idx] = 1'b1;
            buf_d.dat[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q <= '0;
        end else begin
            buf_q <= buf_d;
        end
    end

    assign vld     = buf_q.vld;
    assign dat     = buf_q.dat;
    assign any_vld = |buf_q.vld;

    // R5: flags are empty after a commit
    p_flags_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !wr_en |=> vld == '0);

    // R3: a stored byte lands in the addressed slot
    p_slot_written_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> vld[$past(wr_idx)] && dat[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/pws_prog_timer.sv
module pws_prog_timer #(
    parameter int unsigned PROG_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic fire
);
    import pws_pkg::*;

    localparam int unsigned CNT_W = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        prog_phase_e      ph;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic last_cycle;

    assign last_cycle = (tmr_q.ph == PH_PROG) && (tmr_q.cnt == '0);

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.ph == PH_IDLE) begin
            if (start) begin
                tmr_d.ph  = PH_PROG;
                tmr_d.cnt = CNT_W'(PROG_CYCLES - 1);
            end
        end else if (last_cycle) begin
            tmr_d.ph = PH_IDLE;
        end else begin
            tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '{ph: PH_IDLE, cnt: '0};
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy = (tmr_q.ph == PH_PROG);
    assign fire = last_cycle;

    // R4: start raises busy on the next clock
    p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R4: busy holds until the count is spent
    p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !fire |=> busy);

    // R8: no restart while a period runs
    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/pws_array.sv
module pws_array #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned PAGE_W = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 commit,
    input  logic [ADDR_W-PAGE_W-1:0]             tag,
    input  logic [(1<<PAGE_W)-1:0]               vld,
    input  logic [(1<<PAGE_W)-1:0][DATA_W-1:0]   dat,
    input  logic [ADDR_W-1:0]                    rd_addr,
    output logic [DATA_W-1:0]                    rd_data
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned SLOTS = 1 << PAGE_W;
    localparam int unsigned TAG_W = ADDR_W - PAGE_W;

    logic [DEPTH-1:0][DATA_W-1:0] mem_d, mem_q;

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        localparam int unsigned SLOT = w % SLOTS;
        localparam int unsigned PAGE = w / SLOTS;
        assign mem_d[w] = (commit && tag == TAG_W'(PAGE) && vld[SLOT])
                          ? dat[SLOT] : mem_q[w];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd_data = mem_q[rd_addr];

    // R4: the array is quiet outside a commit
    p_array_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(mem_q));

endmodule

// File: rtl/page_write_sequencer.sv
module page_write_sequencer #(
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned PAGE_W      = 4,
    parameter int unsigned PROG_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              wr_byte,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_adv,
    input  logic              stop,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    import pws_pkg::*;

    localparam int unsigned SLOTS = 1 << PAGE_W;
    localparam int unsigned TAG_W = ADDR_W - PAGE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        logic [TAG_W-1:0]  tag;
    } seq_t;

    seq_t seq_d, seq_q;
    evt_t ev;

    logic                         any_vld;
    logic                         fire;
    logic [SLOTS-1:0]             pg_vld;
    logic [SLOTS-1:0][DATA_W-1:0] pg_dat;

    // Event decode: all blocked while busy; load > write > step
    always_comb begin
        ev       = '0;
        ev.load  = addr_load && !busy;
        ev.write = wr_byte && !busy && !addr_load;
        ev.step  = rd_adv && !busy && !addr_load && !wr_byte;
        ev.start = stop && !busy && any_vld;
    end

    always_comb begin
        seq_d = seq_q;
        if (ev.load) begin
            seq_d.ptr = addr_in;
        end else if (ev.write) begin
            seq_d.ptr[PAGE_W-1:0] = seq_q.ptr[PAGE_W-1:0] + PAGE_W'(1);
            if (!any_vld) begin
                seq_d.tag = seq_q.ptr[ADDR_W-1:PAGE_W];
            end
        end else if (ev.step) begin
            seq_d.ptr = seq_q.ptr + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    pws_page_buffer #(
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ev.write),
        .wr_idx  (seq_q.ptr[PAGE_W-1:0]),
        .wr_data (wr_data),
        .clr     (fire),
        .vld     (pg_vld),
        .dat     (pg_dat),
        .any_vld (any_vld)
    );

    pws_prog_timer #(
        .PROG_CYCLES (PROG_CYCLES)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ev.start),
        .busy  (busy),
        .fire  (fire)
    );

    pws_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .PAGE_W (PAGE_W)
    ) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (fire),
        .tag     (seq_q.tag),
        .vld     (pg_vld),
        .dat     (pg_dat),
        .rd_addr (seq_q.ptr),
        .rd_data (rd_data)
    );

    // R3: upper pointer bits survive a write step
    p_page_hi_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_byte && !busy && !addr_load
        |=> seq_q.ptr[ADDR_W-1:PAGE_W] == $past(seq_q.ptr[ADDR_W-1:PAGE_W]));

    // R7: read step covers all bits
    p_rd_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_adv && !busy && !addr_load && !wr_byte
        |=> seq_q.ptr == $past(seq_q.ptr) + ADDR_W'(1));

    // R6: empty STOP leaves busy low
    p_dummy_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop && !busy && !any_vld |=> !busy);

    // R8: pointer frozen while busy
    p_busy_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(seq_q.ptr));

    // R2: address load takes effect
    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load && !busy |=> seq_q.ptr == $past(addr_in));

endmodule

// File: tb/page_write_sequencer_tb.sv
module page_write_sequencer_tb;

    localparam int PROG = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_load = 1'b0;
    logic [7:0] addr_in = '0;
    logic       wr_byte = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_adv = 1'b0;
    logic       stop = 1'b0;
    logic [7:0] rd_data;
    logic       busy;

    always #10 clk = ~clk;

    page_write_sequencer #(
        .ADDR_W      (8),
        .DATA_W      (8),
        .PAGE_W      (4),
        .PROG_CYCLES (PROG)
    ) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_load (addr_load),
        .addr_in   (addr_in),
        .wr_byte   (wr_byte),
        .wr_data   (wr_data),
        .rd_adv    (rd_adv),
        .stop      (stop),
        .rd_data   (rd_data),
        .busy      (busy)
    );

    int n_vec = 0;
    int n_err = 0;
    bit done  = 0;

    // Reference model
    logic [7:0] m_mem [256];
    logic [7:0] m_buf [16];
    bit         m_vld [16];
    logic [3:0] m_tag;
    logic [7:0] m_ptr;

    typedef struct {
        logic [7:0] v;
        string      req;
    } exp_t;
    exp_t exp_q[$];

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_vec++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
            $finish;
        end
    endtask

    // Monitor: compares read data against queued expectations
    initial begin
        forever begin
            exp_t it;
            wait (exp_q.size() != 0);
            #1;
            it = exp_q.pop_front();
            chk(rd_data === it.v, it.req, rd_data, it.v);
        end
    end

    task automatic do_addr(input logic [7:0] a);
        @(negedge clk);
        addr_load = 1'b1;
        addr_in   = a;
        @(negedge clk);
        addr_load = 1'b0;
        m_ptr     = a;
    endtask

    task automatic do_wr(input logic [7:0] d);
        bit any = 0;
        @(negedge clk);
        wr_byte = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_byte = 1'b0;
        for (int i = 0; i < 16; i++) any |= m_vld[i];
        if (!any) m_tag = m_ptr[7:4];
        m_buf[m_ptr[3:0]] = d;
        m_vld[m_ptr[3:0]] = 1;
        m_ptr[3:0]        = m_ptr[3:0] + 4'd1;
    endtask

    task automatic do_read(input string req);
        @(negedge clk);
        exp_q.push_back('{v: m_mem[m_ptr], req: req});
        rd_adv = 1'b1;
        @(negedge clk);
        rd_adv = 1'b0;
        m_ptr  = m_ptr + 8'd1;
    endtask

    // STOP; optionally fire every event mid-period
    task automatic do_stop(input bit intrude);
        bit any = 0;
        for (int i = 0; i < 16; i++) any |= m_vld[i];
        @(negedge clk);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        if (!any) begin
            for (int i = 0; i < 3; i++) begin
                chk(busy === 1'b0, "R6 empty stop busy", busy, 0);
                @(negedge clk);
            end
            return;
        end
        for (int i = 0; i < PROG; i++) begin
            chk(busy === 1'b1, "R4 busy during period", busy, 1);
            if (i == 0)
                chk(rd_data === m_mem[m_ptr], "R4 old data while busy", rd_data, m_mem[m_ptr]);
            if (intrude && i == 1) begin
                addr_load = 1'b1; addr_in = 8'h00; stop = 1'b1;
            end
            if (intrude && i == 2) begin
                addr_load = 1'b0; wr_byte = 1'b1; wr_data = 8'hEE;
            end
            if (intrude && i == 3) begin
                wr_byte = 1'b0; rd_adv = 1'b1; stop = 1'b0;
            end
            if (intrude && i == 4) rd_adv = 1'b0;
            @(negedge clk);
        end
        chk(busy === 1'b0, "R4 busy ends after PROG cycles", busy, 0);
        for (int i = 0; i < 16; i++) begin
            if (m_vld[i]) m_mem[{m_tag, 4'(i)}] = m_buf[i];
            m_vld[i] = 0;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_vec++;
        n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
        for (int i = 0; i < 16; i++) begin m_vld[i] = 0; m_buf[i] = 8'h00; end
        m_tag = '0;
        m_ptr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "R1 reset busy", busy, 0);
        chk(rd_data === 8'h00, "R1 reset data", rd_data, 0);

        // Full page
        do_addr(8'h20);
        for (int i = 0; i < 16; i++) do_wr(8'h10 + 8'(i));
        chk(m_ptr == 8'h20, "R9 model pointer wrap", m_ptr, 8'h20);
        do_stop(0);
        do_read("R9 pointer after full page");
        do_addr(8'h20);
        for (int i = 0; i < 16; i++) do_read("R2 R3 full page readback");

        // Page wrap write, events fired while busy
        do_addr(8'h2E);
        do_wr(8'hB0); do_wr(8'hB1); do_wr(8'hB2); do_wr(8'hB3);
        do_stop(1);
        do_read("R8 R9 pointer kept after busy");
        do_read("R5 untouched byte");
        do_addr(8'h2E);
        do_read("R3 wrap slot 2E");
        do_read("R3 wrap slot 2F");
        do_read("R7 read crosses page");
        do_addr(8'h20);
        do_read("R3 wrapped byte 20");
        do_read("R3 wrapped byte 21");
        do_read("R5 unwritten keeps value");
        do_addr(8'h00);
        do_read("R8 ignored write not stored");

        // 17 bytes: overwrite
        do_addr(8'h50);
        for (int i = 0; i < 16; i++) do_wr(8'hC0 + 8'(i));
        do_wr(8'hD0);
        do_stop(0);
        do_read("R9 pointer after 17 bytes");
        do_addr(8'h50);
        do_read("R3 17th byte overwrote");
        do_read("R3 neighbour intact");

        // Address-only transfer, and valid flags cleared
        do_addr(8'h70);
        do_stop(0);
        do_read("R6 dummy write no change");

        // Read wrap 0xFF -> 0x00
        do_addr(8'hFF);
        do_wr(8'h77);
        do_stop(0);
        do_read("R3 in-page wrap to F0");
        do_addr(8'h00);
        do_wr(8'h66);
        do_stop(0);
        do_addr(8'hFF);
        do_read("R7 read at FF");
        do_read("R7 read wrapped to 00");

        // Priority: load and write in one cycle
        @(negedge clk);
        addr_load = 1'b1; addr_in = 8'h23; wr_byte = 1'b1; wr_data = 8'h99; rd_adv = 1'b1;
        @(negedge clk);
        addr_load = 1'b0; wr_byte = 1'b0; rd_adv = 1'b0;
        m_ptr = 8'h23;
        do_stop(0);
        do_read("R10 load wins, no write buffered");
        // Write beats read advance
        do_addr(8'h60);
        @(negedge clk);
        wr_byte = 1'b1; wr_data = 8'h5A; rd_adv = 1'b1;
        @(negedge clk);
        wr_byte = 1'b0; rd_adv = 1'b0;
        m_tag = 4'h6; m_buf[0] = 8'h5A; m_vld[0] = 1; m_ptr = 8'h61;
        do_stop(0);
        do_addr(8'h60);
        do_read("R10 write wins over step");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule